// File: doc/BRIEF.md
# Prioritized Bus Interrupt Aggregator

This block gathers seven prioritized backplane request levels and a group of special event sources into sticky status bits, one per source. Each status bit is recorded only while its enable bit is set. A held status bit raises one of eight local interrupt lines, chosen by a 3-bit routing field per source, and only while that source stays enabled. When a level request is taken, the acknowledge vector and error flag offered for that level are stored in a per-level status/ID register. The acknowledge bus cycle itself is outside the block and arrives as plain inputs.

Software works through a small word-addressed register port. It sets the enables, clears status bits by writing ones, programs two routing maps and reads the captured vectors. A level whose status bit is still set takes no further acknowledge. Software can therefore drop a level's enable to silence its output while it services a higher level, and the pending request is not lost. A registered output reports the highest enabled pending level, with level 7 ranking first.

Top module: `bus_irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, the enable, status, both routing maps, all status/ID registers, `irq_out` and `top_level` read as zero.
- R2: A request on `src_req` sets its status bit at the next clock edge only if that source's enable bit is 1. With the enable at 0 the request leaves no trace.
- R3: Writing the status register (address 1) clears each status bit whose data bit is 1. Bits written with 0 keep their value.
- R4: Clearing an enable bit forces that source's contribution to `irq_out` low. Its status bit stays set.
- R5: While a level's status bit (bits 1 to 7 of the status word) is set, new requests at that level are not taken, and its status/ID register keeps the earlier vector.
- R6: Routing map 0 (address 2) holds one 3-bit line number per source in bits 4k+2..4k. Field 0 belongs to bus ownership (status bit 0) and field n to level n.
- R7: Routing map 1 (address 3) holds the line number of the special source at status bit 8+j in bits 4j+2..4j. The status bits are: 8 DMA done, 9 local error, 10 bus error, 11 software acknowledge, 12 software interrupt, 13 system fail, 14 power fail.
- R8: `top_level` gives the highest level n (1 to 7) whose status and enable are both set, or 0 if there is none. It is registered, one cycle behind the status.
- R9: For a special source (bits 0 and 8 to 14), a software clear and a new capture landing in the same cycle leave the bit set.
- R10: The status/ID register of level n sits at address 3+n. Bits 7..0 hold the acknowledge vector captured with the request and bit 8 holds the acknowledge error flag.
- R11: Address 0 is the enable register. A read returns data on `reg_rdata` one cycle after `reg_rd`, and the data holds until the next read.
- R12: Each `irq_out` line is the OR of all sources routed to it that are both set and enabled, registered one cycle after the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_req | input | 15 | Request per source, in status bit layout |
| ack_vec | input | 56 | Acknowledge vector per level, level n in bits 8n-1..8n-8 |
| ack_err | input | 7 | Acknowledge failure flag per level, level n at bit n-1 |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe, single cycle |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| irq_out | output | 8 | Local interrupt lines, active high |
| top_level | output | 3 | Highest enabled pending level, 0 if none |

## Verification
The first pattern drives a request with its enable clear and then with it set, and it tells the enable gate apart from a capture that always happens. Repeating a request at a level that is still set, with a different vector, shows whether the acknowledge is really blocked or only the status bit is sticky. Two levels routed to the same line and cleared one at a time separate OR-combining from last-writer routing, and they also show the priority output stepping down. A special source held active while it is being cleared shows which side wins the same-cycle collision.

// File: rtl/irq_agg_pkg.sv
// Package: shared register addresses and map-field geometry for the
// interrupt aggregator. Assumes word addressing on the register port.
package irq_agg_pkg;
    localparam int unsigned ADDR_ENABLE = 0;
    localparam int unsigned ADDR_STATUS = 1;
    localparam int unsigned ADDR_MAP0   = 2;
    localparam int unsigned ADDR_MAP1   = 3;
    localparam int unsigned ADDR_SID0   = 4;  // level 1 status/ID, then ascending
    localparam int unsigned FIELD_W     = 4;  // spacing of routing fields in a map word
endpackage

// File: rtl/irq_status_bank.sv
// Module: irq_status_bank
// Holds the enable and sticky status bits for every source, plus the
// per-level status/ID registers. Status bit 0 is bus ownership, bits
// 1..NUM_LVL are request levels, the rest are special events.
// Assumes src_req is already synchronous to clk.
module irq_status_bank #(
    parameter int NSRC    = 15,
    parameter int NUM_LVL = 7,
    parameter int VEC_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSRC-1:0]               src_req,
    input  logic                          en_we,
    input  logic [NSRC-1:0]               en_wdata,
    input  logic                          clr_we,
    input  logic [NSRC-1:0]               clr_mask,
    input  logic [NUM_LVL*VEC_W-1:0]      ack_vec,
    input  logic [NUM_LVL-1:0]            ack_err,
    output logic [NSRC-1:0]               en_q,
    output logic [NSRC-1:0]               stat_q,
    output logic [NUM_LVL-1:0][VEC_W:0]   sid_q
);

    logic [NSRC-1:0] cap;
    logic [NSRC-1:0] clr_eff;

    // Capture qualifier per source: level bits are also blocked while set.
    for (genvar s = 0; s < NSRC; s++) begin : g_cap
        if (s >= 1 && s <= NUM_LVL) begin : g_lvl
            assign cap[s] = src_req[s] & en_q[s] & ~stat_q[s];
        end else begin : g_spc
            assign cap[s] = src_req[s] & en_q[s];
        end
    end

    assign clr_eff = clr_we ? clr_mask : '0;

    // Enable register and sticky status with capture overriding clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            stat_q <= '0;
        end else begin
            if (en_we) begin
                en_q <= en_wdata;
            end
            stat_q <= (stat_q & ~clr_eff) | cap;
        end
    end

    // Per-level status/ID: latch vector and error flag on acknowledge.
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_sid
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sid_q[i] <= '0;
            end else if (cap[i+1]) begin
                sid_q[i] <= {ack_err[i], ack_vec[i*VEC_W +: VEC_W]};
            end
        end

        AST_SID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            stat_q[i+1] |=> $stable(sid_q[i])); // R5
    end

    AST_GATED_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~$past(stat_q) & ~$past(en_q)) == '0); // R2

    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((clr_mask & stat_q) == '0)) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R3

endmodule

// File: rtl/irq_route_matrix.sv
// Module: irq_route_matrix
// Holds the two routing map words and builds the registered output
// lines. Each source owns a SEL_W-bit field spaced FIELD_W apart;
// sources below FPW use map 0, the rest map 1.
// Assumes NUM_OUT is a power of two and NSRC <= 2*FPW.
module irq_route_matrix #(
    parameter int NSRC    = 15,
    parameter int NUM_OUT = 8,
    parameter int DW      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                map0_we,
    input  logic                map1_we,
    input  logic [DW-1:0]       wdata,
    input  logic [NSRC-1:0]     stat_q,
    input  logic [NSRC-1:0]     en_q,
    output logic [DW-1:0]       map0_q,
    output logic [DW-1:0]       map1_q,
    output logic [NUM_OUT-1:0]  irq_out
);
    import irq_agg_pkg::*;

    localparam int SEL_W = $clog2(NUM_OUT);
    localparam int FPW   = DW / FIELD_W;

    logic [NSRC-1:0]            act;
    logic [NSRC-1:0][SEL_W-1:0] sel;
    logic [NUM_OUT-1:0]         irq_nxt;

    assign act = stat_q & en_q;

    // Field extraction: pick the line number for each source.
    for (genvar s = 0; s < NSRC; s++) begin : g_sel
        if (s < FPW) begin : g_m0
            assign sel[s] = map0_q[s*FIELD_W +: SEL_W];
        end else begin : g_m1
            assign sel[s] = map1_q[(s-FPW)*FIELD_W +: SEL_W];
        end
    end

    // Map registers: written whole, reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map0_q <= '0;
            map1_q <= '0;
        end else begin
            if (map0_we) map0_q <= wdata;
            if (map1_we) map1_q <= wdata;
        end
    end

    // OR every active source into the line it selects.
    always_comb begin
        irq_nxt = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (act[s]) irq_nxt[sel[s]] = 1'b1;
        end
    end

    // Register the output lines.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= irq_nxt;
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & en_q) == '0) |=> (irq_out == '0)); // R4

endmodule

// File: rtl/irq_level_prio.sv
// Module: irq_level_prio
// Registered priority encoder over enabled pending levels; the highest
// numbered level wins and 0 means nothing pending.
// Assumes pend[i] represents level i+1.
module irq_level_prio #(
    parameter int NUM_LVL = 7,
    parameter int LW      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] pend,
    output logic [LW-1:0]      top_q
);

    logic [LW-1:0] best;

    // Ascending scan so the highest pending level is left in best.
    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (pend[i]) best = LW'(i + 1);
        end
    end

    // Register the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= best;
    end

    AST_TOP_LEVEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pend[NUM_LVL-1] |=> (top_q == LW'(NUM_LVL))); // R8

endmodule

// File: rtl/bus_irq_aggregator.sv
// Module: bus_irq_aggregator (top)
// Ties the status bank, route matrix and priority encoder to a word-
// addressed register port: single-cycle writes, reads one cycle late.
// Assumes reg_wr and reg_rd are synchronous to clk.
module bus_irq_aggregator #(
    parameter int NUM_LVL = 7,
    parameter int NUM_SPC = 7,
    parameter int VEC_W   = 8,
    parameter int NUM_OUT = 8,
    parameter int DW      = 32,
    parameter int AW      = 4,
    parameter int NSRC    = 1 + NUM_LVL + NUM_SPC,
    parameter int LW      = $clog2(NUM_LVL + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           src_req,
    input  logic [NUM_LVL*VEC_W-1:0]  ack_vec,
    input  logic [NUM_LVL-1:0]        ack_err,
    input  logic [AW-1:0]             reg_addr,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [DW-1:0]             reg_wdata,
    output logic [DW-1:0]             reg_rdata,
    output logic [NUM_OUT-1:0]        irq_out,
    output logic [LW-1:0]             top_level
);
    import irq_agg_pkg::*;

    logic [NSRC-1:0]              en_q;
    logic [NSRC-1:0]              stat_q;
    logic [NUM_LVL-1:0][VEC_W:0]  sid_q;
    logic [DW-1:0]                map0_q;
    logic [DW-1:0]                map1_q;
    logic [DW-1:0]                rd_mux;
    logic                         en_we, clr_we, map0_we, map1_we;

    // Write decode.
    assign en_we   = reg_wr && (reg_addr == AW'(ADDR_ENABLE));
    assign clr_we  = reg_wr && (reg_addr == AW'(ADDR_STATUS));
    assign map0_we = reg_wr && (reg_addr == AW'(ADDR_MAP0));
    assign map1_we = reg_wr && (reg_addr == AW'(ADDR_MAP1));

    irq_status_bank #(.NSRC(NSRC), .NUM_LVL(NUM_LVL), .VEC_W(VEC_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .en_we    (en_we),
        .en_wdata (reg_wdata[NSRC-1:0]),
        .clr_we   (clr_we),
        .clr_mask (reg_wdata[NSRC-1:0]),
        .ack_vec  (ack_vec),
        .ack_err  (ack_err),
        .en_q     (en_q),
        .stat_q   (stat_q),
        .sid_q    (sid_q)
    );

    irq_route_matrix #(.NSRC(NSRC), .NUM_OUT(NUM_OUT), .DW(DW)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .map0_we (map0_we),
        .map1_we (map1_we),
        .wdata   (reg_wdata),
        .stat_q  (stat_q),
        .en_q    (en_q),
        .map0_q  (map0_q),
        .map1_q  (map1_q),
        .irq_out (irq_out)
    );

    irq_level_prio #(.NUM_LVL(NUM_LVL), .LW(LW)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (stat_q[NUM_LVL:1] & en_q[NUM_LVL:1]),
        .top_q (top_level)
    );

    // Read multiplexer over all readable registers.
    always_comb begin
        rd_mux = '0;
        if (reg_addr == AW'(ADDR_ENABLE))      rd_mux = DW'(en_q);
        else if (reg_addr == AW'(ADDR_STATUS)) rd_mux = DW'(stat_q);
        else if (reg_addr == AW'(ADDR_MAP0))   rd_mux = map0_q;
        else if (reg_addr == AW'(ADDR_MAP1))   rd_mux = map1_q;
        else begin
            for (int i = 0; i < NUM_LVL; i++) begin
                if (reg_addr == AW'(ADDR_SID0 + i)) rd_mux = DW'(sid_q[i]);
            end
        end
    end

    // Read data register: one-cycle latency, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R11

endmodule

// File: tb/tb_bus_irq_aggregator.sv
module tb_bus_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] src_req;
    logic [55:0] ack_vec;
    logic [6:0]  ack_err;
    logic [3:0]  reg_addr;
    logic        reg_wr, reg_rd;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_out;
    logic [2:0]  top_level;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    bus_irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .ack_vec(ack_vec),
        .ack_err(ack_err), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
        .top_level(top_level)
    );

    always #5 clk = ~clk;

    // Behavioural reference state
    logic [14:0] m_en, m_stat;
    logic [31:0] m_map0, m_map1, m_rd;
    logic [8:0]  m_sid [7];
    logic [7:0]  m_irq;
    int          m_top;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Reference model update at each rising edge
    always @(posedge clk) begin : mdl
        logic [14:0] cap;
        logic [7:0]  nirq;
        int          ntop;
        int          line;
        logic [31:0] nrd;
        if (!rst_n) begin
            m_en = 0; m_stat = 0; m_map0 = 0; m_map1 = 0; m_rd = 0;
            m_irq = 0; m_top = 0;
            for (int k = 0; k < 7; k++) m_sid[k] = 0;
        end else begin
            cap = src_req & m_en;
            for (int lv = 1; lv <= 7; lv++) if (m_stat[lv]) cap[lv] = 1'b0;
            nirq = 0;
            for (int s = 0; s < 15; s++) begin
                if (m_stat[s] && m_en[s]) begin
                    line = (s < 8) ? int'((m_map0 >> (4*s)) & 7) : int'((m_map1 >> (4*(s-8))) & 7);
                    nirq[line] = 1'b1;
                end
            end
            ntop = 0;
            for (int lv = 1; lv <= 7; lv++) if (m_stat[lv] && m_en[lv]) ntop = lv;
            nrd = m_rd;
            if (reg_rd) begin
                case (reg_addr)
                    4'd0: nrd = {17'b0, m_en};
                    4'd1: nrd = {17'b0, m_stat};
                    4'd2: nrd = m_map0;
                    4'd3: nrd = m_map1;
                    default: nrd = (reg_addr >= 4 && reg_addr <= 10) ? {23'b0, m_sid[reg_addr-4]} : 32'b0;
                endcase
            end
            for (int lv = 1; lv <= 7; lv++)
                if (cap[lv]) m_sid[lv-1] = {ack_err[lv-1], ack_vec[(lv-1)*8 +: 8]};
            m_stat = (m_stat & ~((reg_wr && reg_addr == 1) ? reg_wdata[14:0] : 15'b0)) | cap;
            if (reg_wr && reg_addr == 0) m_en = reg_wdata[14:0];
            if (reg_wr && reg_addr == 2) m_map0 = reg_wdata;
            if (reg_wr && reg_addr == 3) m_map1 = reg_wdata;
            m_irq = nirq; m_top = ntop; m_rd = nrd;
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk("R12 model irq_out", {24'b0, irq_out}, {24'b0, m_irq});
            chk("R8 model top_level", {29'b0, top_level}, 32'(m_top));
            chk("R11 model reg_rdata", reg_rdata, m_rd);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse(input logic [14:0] m);
        @(negedge clk);
        src_req = src_req | m;
        @(negedge clk);
        src_req = src_req & ~m;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        rst_n = 0; src_req = 0; ack_vec = 0; ack_err = 0;
        reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 irq_out after reset", {24'b0, irq_out}, 0);
        chk("R1 top_level after reset", {29'b0, top_level}, 0);
        rd_chk(0, 0, "R1 enable after reset");
        rd_chk(1, 0, "R1 status after reset");
        rd_chk(2, 0, "R1 map0 after reset");
        rd_chk(6, 0, "R1 level3 status/ID after reset");
        // R2: request while disabled leaves no trace
        pulse(15'h0008);
        idle(1);
        rd_chk(1, 0, "R2 disabled request not captured");
        chk("R2 irq_out stays low", {24'b0, irq_out}, 0);
        // R6/R3/R10: route level 3 to line 5, capture vector A5
        wr(2, 32'h0000_5000);
        wr(0, 32'h0000_0008);
        ack_vec[23:16] = 8'hA5; ack_err[2] = 0;
        pulse(15'h0008);
        idle(2);
        chk("R6 level3 on line 5", {24'b0, irq_out}, 32'h20);
        rd_chk(1, 32'h8, "R3 status bit3 set");
        rd_chk(6, 32'h0A5, "R10 level3 vector latched");
        // R11: read data holds without a new read
        idle(2);
        chk("R11 read data held", reg_rdata, 32'h0A5);
        // R5: second request at set level is not taken
        ack_vec[23:16] = 8'h3C; ack_err[2] = 1;
        pulse(15'h0008);
        idle(1);
        rd_chk(6, 32'h0A5, "R5 vector not relatched");
        // R4: masking keeps status
        wr(0, 0);
        idle(2);
        chk("R4 masked output low", {24'b0, irq_out}, 0);
        rd_chk(1, 32'h8, "R4 status kept while masked");
        // R3: write-one-to-clear
        wr(1, 0);
        rd_chk(1, 32'h8, "R3 zero write keeps bit");
        wr(1, 32'h8);
        rd_chk(1, 0, "R3 one write clears bit");
        // R10: error flag
        wr(0, 32'h8);
        pulse(15'h0008);
        idle(1);
        rd_chk(6, 32'h13C, "R10 vector with error flag");
        wr(1, 32'h8);
        wr(0, 0);
        // R7: DMA done (bit 8) through map1 field 0 to line 2
        wr(3, 32'h0000_0002);
        wr(0, 32'h0100);
        pulse(15'h0100);
        idle(2);
        chk("R7 DMA on line 2", {24'b0, irq_out}, 32'h04);
        rd_chk(1, 32'h100, "R7 DMA status at bit 8");
        // R9: capture wins over clear on a held special source
        @(negedge clk); src_req = 15'h0100;
        idle(2);
        wr(1, 32'h100);
        rd_chk(1, 32'h100, "R9 capture beats clear");
        @(negedge clk); src_req = 0;
        wr(1, 32'h100);
        rd_chk(1, 0, "R9 clear after request drops");
        wr(0, 0);
        // R8/R12: levels 2 and 6 both on line 1
        wr(2, 32'h0100_0100);
        wr(0, 32'h0044);
        pulse(15'h0044);
        idle(2);
        chk("R8 level6 wins", {29'b0, top_level}, 6);
        chk("R12 shared line 1 high", {24'b0, irq_out}, 32'h02);
        wr(1, 32'h40);
        idle(2);
        chk("R8 level2 after level6 cleared", {29'b0, top_level}, 2);
        chk("R12 line 1 still high", {24'b0, irq_out}, 32'h02);
        wr(1, 32'h04);
        idle(2);
        chk("R12 line 1 low after both cleared", {24'b0, irq_out}, 0);
        chk("R8 nothing pending", {29'b0, top_level}, 0);
        idle(2);
        report();
    end
endmodule